// File: doc/BRIEF.md
# Next Fetch Address Unit

This block decides where a 32-bit core with fixed 4-byte, word-aligned instructions fetches next. Each cycle it takes the address of the current instruction, a 3-bit control class from the decoder, two register operand values, a 16-bit branch displacement, a 26-bit direct-jump field and an optional link register index. It returns the following fetch address, a flag that says control flow left the straight line, and a link write (enable, register index, value) for the call forms.

Conditional branches compare the two operands for equality or inequality and land relative to the sequential address, with the displacement counted in instructions. Direct jumps keep the top bits of the sequential address and fill the rest from the jump field. Register jumps go to any word-aligned address held in the first operand. A register target with either of its two low bits set is refused: the unit flags an alignment error and falls through instead. All results are registered, so outputs reflect the inputs sampled at the previous rising clock edge.

Top module: `npc_unit`

## Requirements
- R1: While reset is asserted (rst_n low) and on the first edge after, nxt_pc is 0 and redirect, link_we and align_err are 0.
- R2: Every output reflects the inputs sampled at the previous rising edge (one cycle of latency); with class 0 (sequential) or class 7 (reserved), nxt_pc is cur_pc+4, redirect is 0 and link_we is 0.
- R3: Class 1 (branch-if-equal) with opnd_a equal to opnd_b gives redirect 1 and nxt_pc = cur_pc + 4 + 4 * sign-extended br_offset.
- R4: Class 2 (branch-if-different) with opnd_a not equal to opnd_b gives redirect 1 and the same target formula as R3.
- R5: A branch whose condition fails gives redirect 0 and nxt_pc = cur_pc+4.
- R6: Class 3 (jump) gives redirect 1 and nxt_pc = {bits 31..28 of cur_pc+4, jmp_field, 2'b00}.
- R7: Class 4 (jump-and-link) forms the R6 target and also gives link_we 1, link_idx 31, link_val = cur_pc+4.
- R8: Class 5 (register jump) with opnd_a[1:0] = 0 gives redirect 1 and nxt_pc = opnd_a, with no link write.
- R9: Class 6 (register jump-and-link) with opnd_a[1:0] = 0 gives redirect 1, nxt_pc = opnd_a, link_we 1, link_val = cur_pc+4, and link_idx = link_sel, or 31 when link_sel is 0.
- R10: Class 5 or 6 with opnd_a[1:0] not 0 gives align_err 1, redirect 0, link_we 0 and nxt_pc = cur_pc+4; align_err is 0 for every other case.
- R11: The sequential address cur_pc+4 wraps modulo 2^32 (0xFFFFFFFC steps to 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_pc | input | 32 | Address of the current instruction |
| ctl_class | input | 3 | Control class: 0 seq, 1 br-eq, 2 br-ne, 3 jump, 4 jump-link, 5 reg-jump, 6 reg-jump-link, 7 reserved |
| opnd_a | input | 32 | First register operand, also the register-jump target |
| opnd_b | input | 32 | Second register operand for branch compare |
| br_offset | input | 16 | Signed branch displacement in instructions |
| jmp_field | input | 26 | Direct-jump word index field |
| link_sel | input | 5 | Named link register for class 6, 0 selects 31 |
| nxt_pc | output | 32 | Next fetch address |
| redirect | output | 1 | Control flow left the sequential path |
| link_we | output | 1 | Link write enable |
| link_idx | output | 5 | Link destination register |
| link_val | output | 32 | Return address to write |
| align_err | output | 1 | Register-jump target not word aligned |

## Verification
The register jump-and-link class both redirects and writes a link in one cycle, and it can also meet the alignment check in that same cycle. The bench drives class 6 with an aligned target (with link_sel 0 and a named register) and again with a target whose low bits are 2'b10, then judges that the redirect and the link write appear together in the first case and that both are withdrawn, with align_err raised and the fall-through address chosen, in the second. Branches at the extreme negative displacement and sequential steps at the top of the address space are run back to back against a scoreboard of expected results.

// File: rtl/npc_pkg.sv
package npc_pkg;

    typedef enum logic [2:0] {
        CTL_SEQ   = 3'd0,
        CTL_BEQ   = 3'd1,
        CTL_BNE   = 3'd2,
        CTL_JMP   = 3'd3,
        CTL_JAL   = 3'd4,
        CTL_JREG  = 3'd5,
        CTL_JREGL = 3'd6,
        CTL_RSVD  = 3'd7
    } ctl_class_e;

    // Register that receives the return address when none is named.
    localparam int unsigned LINK_DEFAULT = 31;

endpackage

// File: rtl/npc_step_add.sv
// Sequential address and PC-relative branch target.
module npc_step_add #(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned OFF_W   = 16,
    parameter int unsigned ALIGN_W = 2
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [OFF_W-1:0] offset,
    output logic [XLEN-1:0]  pc_step,
    output logic [XLEN-1:0]  br_tgt
);
    localparam int unsigned EXT_W = XLEN - OFF_W - ALIGN_W;
    localparam logic [XLEN-1:0] INSTR_BYTES = XLEN'(1 << ALIGN_W);

    logic [XLEN-1:0] disp;

    always_comb begin
        disp    = {{EXT_W{offset[OFF_W-1]}}, offset, {ALIGN_W{1'b0}}};
        pc_step = pc + INSTR_BYTES;
        br_tgt  = pc_step + disp;
    end
endmodule

// File: rtl/npc_cond.sv
// Operand equality for conditional branches.
module npc_cond #(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] lhs,
    input  logic [XLEN-1:0] rhs,
    output logic            same
);
    always_comb begin
        same = (lhs == rhs);
    end
endmodule

// File: rtl/npc_select.sv
// Chooses the next address and link write from the control class.
module npc_select
    import npc_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned JFLD_W  = 26,
    parameter int unsigned RIDX_W  = 5,
    parameter int unsigned ALIGN_W = 2
) (
    input  logic [2:0]        ctl,
    input  logic [XLEN-1:0]   pc_step,
    input  logic [XLEN-1:0]   br_tgt,
    input  logic              same,
    input  logic [XLEN-1:0]   reg_tgt,
    input  logic [JFLD_W-1:0] jfield,
    input  logic [RIDX_W-1:0] lsel,
    output logic [XLEN-1:0]   sel_pc,
    output logic              sel_redirect,
    output logic              sel_lwe,
    output logic [RIDX_W-1:0] sel_lidx,
    output logic [XLEN-1:0]   sel_lval,
    output logic              sel_aerr
);
    localparam int unsigned UPPER_W = XLEN - JFLD_W - ALIGN_W;
    localparam logic [RIDX_W-1:0] DEF_IDX = RIDX_W'(LINK_DEFAULT);

    logic [XLEN-1:0]   jmp_tgt;
    logic              reg_ok;
    logic [RIDX_W-1:0] named_idx;

    always_comb begin
        jmp_tgt   = {pc_step[XLEN-1 -: UPPER_W], jfield, {ALIGN_W{1'b0}}};
        reg_ok    = (reg_tgt[ALIGN_W-1:0] == '0);
        named_idx = (lsel == '0) ? DEF_IDX : lsel;

        sel_pc       = pc_step;
        sel_redirect = 1'b0;
        sel_lwe      = 1'b0;
        sel_lidx     = '0;
        sel_lval     = '0;
        sel_aerr     = 1'b0;

        unique case (ctl_class_e'(ctl))
            CTL_SEQ, CTL_RSVD: begin
            end
            CTL_BEQ: begin
                if (same) begin
                    sel_pc       = br_tgt;
                    sel_redirect = 1'b1;
                end
            end
            CTL_BNE: begin
                if (!same) begin
                    sel_pc       = br_tgt;
                    sel_redirect = 1'b1;
                end
            end
            CTL_JMP: begin
                sel_pc       = jmp_tgt;
                sel_redirect = 1'b1;
            end
            CTL_JAL: begin
                sel_pc       = jmp_tgt;
                sel_redirect = 1'b1;
                sel_lwe      = 1'b1;
                sel_lidx     = DEF_IDX;
                sel_lval     = pc_step;
            end
            CTL_JREG: begin
                if (reg_ok) begin
                    sel_pc       = reg_tgt;
                    sel_redirect = 1'b1;
                end else begin
                    sel_aerr = 1'b1;
                end
            end
            CTL_JREGL: begin
                if (reg_ok) begin
                    sel_pc       = reg_tgt;
                    sel_redirect = 1'b1;
                    sel_lwe      = 1'b1;
                    sel_lidx     = named_idx;
                    sel_lval     = pc_step;
                end else begin
                    sel_aerr = 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/npc_unit.sv
// Next fetch address unit: combinational resolve, registered results.
module npc_unit #(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned OFF_W   = 16,
    parameter int unsigned JFLD_W  = 26,
    parameter int unsigned RIDX_W  = 5,
    parameter int unsigned ALIGN_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [2:0]        ctl_class,
    input  logic [XLEN-1:0]   opnd_a,
    input  logic [XLEN-1:0]   opnd_b,
    input  logic [OFF_W-1:0]  br_offset,
    input  logic [JFLD_W-1:0] jmp_field,
    input  logic [RIDX_W-1:0] link_sel,
    output logic [XLEN-1:0]   nxt_pc,
    output logic              redirect,
    output logic              link_we,
    output logic [RIDX_W-1:0] link_idx,
    output logic [XLEN-1:0]   link_val,
    output logic              align_err
);
    logic [XLEN-1:0]   pc_step;
    logic [XLEN-1:0]   br_tgt;
    logic              same;
    logic [XLEN-1:0]   sel_pc;
    logic              sel_redirect;
    logic              sel_lwe;
    logic [RIDX_W-1:0] sel_lidx;
    logic [XLEN-1:0]   sel_lval;
    logic              sel_aerr;

    npc_step_add #(.XLEN(XLEN), .OFF_W(OFF_W), .ALIGN_W(ALIGN_W)) u_step (
        .pc      (cur_pc),
        .offset  (br_offset),
        .pc_step (pc_step),
        .br_tgt  (br_tgt)
    );

    npc_cond #(.XLEN(XLEN)) u_cond (
        .lhs  (opnd_a),
        .rhs  (opnd_b),
        .same (same)
    );

    npc_select #(
        .XLEN(XLEN), .JFLD_W(JFLD_W), .RIDX_W(RIDX_W), .ALIGN_W(ALIGN_W)
    ) u_sel (
        .ctl          (ctl_class),
        .pc_step      (pc_step),
        .br_tgt       (br_tgt),
        .same         (same),
        .reg_tgt      (opnd_a),
        .jfield       (jmp_field),
        .lsel         (link_sel),
        .sel_pc       (sel_pc),
        .sel_redirect (sel_redirect),
        .sel_lwe      (sel_lwe),
        .sel_lidx     (sel_lidx),
        .sel_lval     (sel_lval),
        .sel_aerr     (sel_aerr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt_pc    <= '0;
            redirect  <= 1'b0;
            link_we   <= 1'b0;
            link_idx  <= '0;
            link_val  <= '0;
            align_err <= 1'b0;
        end else begin
            nxt_pc    <= sel_pc;
            redirect  <= sel_redirect;
            link_we   <= sel_lwe;
            link_idx  <= sel_lidx;
            link_val  <= sel_lval;
            align_err <= sel_aerr;
        end
    end
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] cur_pc,
    input logic [2:0]  ctl_class,
    input logic [31:0] opnd_a,
    input logic [4:0]  link_sel,
    input logic [31:0] nxt_pc,
    input logic        redirect,
    input logic        link_we,
    input logic [4:0]  link_idx,
    input logic        align_err
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (nxt_pc == 32'd0) && !redirect && !link_we && !align_err);

    a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_class == 3'd0) |=> (nxt_pc == $past(cur_pc) + 32'd4) && !redirect && !link_we);

    a_r6_jump_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_class == 3'd3) |=> redirect && (nxt_pc[1:0] == 2'b00)
            && (nxt_pc[31:28] == 4'(($past(cur_pc) + 32'd4) >> 28)));

    a_r7_link_default: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_class == 3'd4) |=> link_we && (link_idx == 5'd31));

    a_r9_unnamed_link: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_class == 3'd6) && (opnd_a[1:0] == 2'b00) && (link_sel == 5'd0)
            |=> link_we && (link_idx == 5'd31) && (nxt_pc == $past(opnd_a)));

    a_r10_misalign_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_class == 3'd5) || (ctl_class == 3'd6)) && (opnd_a[1:0] != 2'b00)
            |=> align_err && !redirect && !link_we && (nxt_pc == $past(cur_pc) + 32'd4));

    a_r10_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> !redirect && !link_we);
endmodule

bind npc_unit npc_unit_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cur_pc    (cur_pc),
    .ctl_class (ctl_class),
    .opnd_a    (opnd_a),
    .link_sel  (link_sel),
    .nxt_pc    (nxt_pc),
    .redirect  (redirect),
    .link_we   (link_we),
    .link_idx  (link_idx),
    .align_err (align_err)
);

// File: tb/npc_unit_tb_top.sv
module npc_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cur_pc = '0;
    logic [2:0]  ctl_class = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [15:0] br_offset = '0;
    logic [25:0] jmp_field = '0;
    logic [4:0]  link_sel = '0;
    logic [31:0] nxt_pc;
    logic        redirect;
    logic        link_we;
    logic [4:0]  link_idx;
    logic [31:0] link_val;
    logic        align_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string       tag;
        logic [31:0] pc;
        logic        rd;
        logic        we;
        logic [4:0]  idx;
        logic [31:0] val;
        logic        ae;
    } exp_t;

    exp_t sb_q[$];

    always #4 clk = ~clk;   // 125 MHz

    npc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .ctl_class(ctl_class),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .br_offset(br_offset),
        .jmp_field(jmp_field), .link_sel(link_sel), .nxt_pc(nxt_pc),
        .redirect(redirect), .link_we(link_we), .link_idx(link_idx),
        .link_val(link_val), .align_err(align_err)
    );

    // Expected result written from the requirement text.
    function automatic exp_t model(string tag, logic [31:0] pc, logic [2:0] cls,
                                   logic [31:0] a, logic [31:0] b, logic [15:0] off,
                                   logic [25:0] jf, logic [4:0] ls);
        exp_t e;
        logic [31:0] seq;
        logic [31:0] btgt;
        seq  = pc + 32'd4;
        btgt = seq + ({{16{off[15]}}, off} * 32'd4);
        e.tag = tag; e.pc = seq; e.rd = 0; e.we = 0; e.idx = 0; e.val = 0; e.ae = 0;
        case (cls)
            3'd1: if (a == b) begin e.pc = btgt; e.rd = 1; end
            3'd2: if (a != b) begin e.pc = btgt; e.rd = 1; end
            3'd3: begin e.pc = {seq[31:28], jf, 2'b00}; e.rd = 1; end
            3'd4: begin e.pc = {seq[31:28], jf, 2'b00}; e.rd = 1;
                        e.we = 1; e.idx = 5'd31; e.val = seq; end
            3'd5: if (a[1:0] == 0) begin e.pc = a; e.rd = 1; end else e.ae = 1;
            3'd6: if (a[1:0] == 0) begin e.pc = a; e.rd = 1; e.we = 1;
                        e.idx = (ls == 0) ? 5'd31 : ls; e.val = seq; end
                  else e.ae = 1;
            default: ;
        endcase
        return e;
    endfunction

    task automatic drive(string tag, logic [31:0] pc, logic [2:0] cls,
                         logic [31:0] a, logic [31:0] b, logic [15:0] off,
                         logic [25:0] jf, logic [4:0] ls);
        @(negedge clk);
        cur_pc = pc; ctl_class = cls; opnd_a = a; opnd_b = b;
        br_offset = off; jmp_field = jf; link_sel = ls;
        sb_q.push_back(model(tag, pc, cls, a, b, off, jf, ls));
    endtask

    // Monitor: registered outputs settle after the edge that sampled the inputs.
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (nxt_pc !== e.pc || redirect !== e.rd || link_we !== e.we ||
                    align_err !== e.ae || (e.we && (link_idx !== e.idx || link_val !== e.val))) begin
                    errors++;
                    $display("FAIL %s: got pc=%h rd=%b we=%b idx=%0d val=%h ae=%b exp pc=%h rd=%b we=%b idx=%0d val=%h ae=%b",
                             e.tag, nxt_pc, redirect, link_we, link_idx, link_val, align_err,
                             e.pc, e.rd, e.we, e.idx, e.val, e.ae);
                end
            end
        end
    end

    initial begin
        repeat (3000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet under reset
        checks++;
        if (nxt_pc !== 32'd0 || redirect !== 1'b0 || link_we !== 1'b0 || align_err !== 1'b0) begin
            errors++;
            $display("FAIL R1: got pc=%h rd=%b we=%b ae=%b exp all zero", nxt_pc, redirect, link_we, align_err);
        end
        rst_n = 1'b1;

        drive("R2 seq",          32'h0000_1000, 3'd0, 32'h5, 32'h5, 16'h0010, 26'h0, 5'd0);
        drive("R2 reserved",     32'h0040_0020, 3'd7, 32'h0, 32'h0, 16'h7FFF, 26'h3, 5'd3);
        drive("R11 wrap",        32'hFFFF_FFFC, 3'd0, 32'h0, 32'h1, 16'h0,    26'h0, 5'd0);
        drive("R3 beq fwd",      32'h0000_2000, 3'd1, 32'hAB, 32'hAB, 16'h0003, 26'h0, 5'd0);
        drive("R3 beq min",      32'h0010_0000, 3'd1, 32'h0, 32'h0, 16'h8000, 26'h0, 5'd0);
        drive("R5 beq miss",     32'h0000_2000, 3'd1, 32'h1, 32'h2, 16'h0003, 26'h0, 5'd0);
        drive("R4 bne back",     32'h0000_3000, 3'd2, 32'h1, 32'h2, 16'hFFFF, 26'h0, 5'd0);
        drive("R5 bne miss",     32'h0000_3000, 3'd2, 32'h7, 32'h7, 16'h0040, 26'h0, 5'd0);
        drive("R6 jump upper",   32'h3FFF_FFFC, 3'd3, 32'h0, 32'h0, 16'h0,    26'h2AB_CDEF, 5'd0);
        drive("R6 jump",         32'hA000_0100, 3'd3, 32'h0, 32'h0, 16'h0,    26'h000_0004, 5'd0);
        drive("R7 jal",          32'h0000_4000, 3'd4, 32'h0, 32'h0, 16'h0,    26'h3FF_FFFF, 5'd9);
        drive("R8 jreg",         32'h0000_5000, 3'd5, 32'hFFFF_FFF0, 32'h0, 16'h0, 26'h0, 5'd0);
        drive("R10 jreg odd",    32'h0000_5000, 3'd5, 32'h0000_8001, 32'h0, 16'h0, 26'h0, 5'd0);
        drive("R9 jalr default", 32'h0000_6000, 3'd6, 32'h0001_0000, 32'h0, 16'h0, 26'h0, 5'd0);
        drive("R9 jalr named",   32'h0000_6004, 3'd6, 32'h0002_0008, 32'h0, 16'h0, 26'h0, 5'd7);
        drive("R10 jalr odd",    32'h0000_6008, 3'd6, 32'h0002_000A, 32'h0, 16'h0, 26'h0, 5'd7);
        drive("R2 seq after",    32'h0000_600C, 3'd0, 32'h0002_000A, 32'h0, 16'h0, 26'h0, 5'd7);

        while (sb_q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule